// File: doc/BRIEF.md
# ECC Error Logging Register Bank

This block records memory errors for a single-channel DRAM controller whose 64-bit words carry SECDED check bits. The ECC checker sends it one-cycle pulses. One pulse marks a corrected single-bit error and another marks an uncorrectable multi-bit error. Each pulse comes with the physical address and the 3-bit row index of the access. The block keeps the first error of each kind. Software reads the record through a small register bank and acknowledges it with write-one-to-clear flags.

The error address register is shared by both error classes. It holds the failing address at 4 KB granularity and two flag bits. Once one of its flags is set, it freezes until software clears that flag. The status register has a separate flag and a separate first-row field for each class. The command register enables a level-sensitive system-error output for each class. The mode register holds the 2-bit integrity mode. When the mode is "no checking", error pulses are ignored.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, all four registers read zero and `serr` is low.
- R2: In a checking mode, a single-bit pulse with no address flag set loads the address register. It reads as address bits 31:12 in place, bits 11:2 zero, and bit 0 (single-bit flag) set.
- R3: In a checking mode, a multi-bit pulse with no address flag set loads bits 31:12 of the address and sets bit 1 (multi-bit flag) of the address register.
- R4: Writing register 0 clears each address flag whose write-data bit (bit 0 or bit 1) is 1. A flag whose write-data bit is 0 stays as it is. The address field ignores writes.
- R5: While either address flag is set, later error pulses change neither the address nor the flags of register 0.
- R6: Status register (index 1) bit 0 is set by the first single-bit error. Bits 3:1 hold that error's row. While bit 0 is set, later single-bit errors change neither field.
- R7: Status bit 4 is set by the first multi-bit error. Bits 7:5 hold that error's row. While bit 4 is set, later multi-bit errors change neither field.
- R8: Writing 1 to status bit 0 or bit 4 clears that flag, and the row fields keep their values. No other status bit can be written.
- R9: When single-bit and multi-bit pulses arrive in the same cycle, the multi-bit error owns register 0: bit 1 is set and bit 0 is clear. Both status flags are set, each with the row of that access.
- R10: Command register (index 2) bit 0 enables system-error signalling for single-bit errors and bit 1 does so for multi-bit errors. Both bits read back, and they reset to 0.
- R11: `serr` is high while any status flag is set together with its enable. It falls as soon as software clears the flag or the enable.
- R12: Mode register (index 3) bits 1:0 hold the mode: 00 no checking, 01 check only, 10 correct, 11 correct and scrub. The mode resets to 00. In mode 00, error pulses set no flag. In every other mode, error pulses are recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_sb | input | 1 | Single-bit (corrected) error pulse |
| err_mb | input | 1 | Multi-bit (uncorrectable) error pulse |
| err_addr | input | 32 | Physical address of the checked access |
| err_row | input | 3 | Row index of the checked access |
| cfg_sel | input | 2 | Register index: 0 address, 1 status, 2 command, 3 mode |
| cfg_we | input | 1 | Write strobe for the selected register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| serr | output | 1 | System-error level |

## Verification
The hardest case to reach is a conflict inside one class, where register 0 and the status flags disagree about which error they hold. For example, register 0 may still carry a single-bit record while a multi-bit error sets its own status flag and row. After the single-bit flag is cleared, a later multi-bit error must then load the address while the multi-bit row stays frozen. The stimulus reaches this state by acknowledging flags one at a time, in a chosen order, between error pulses. It also writes zero bits and address-field bits to show that those writes change nothing. A last step with both pulses in the same cycle, in check-only mode, exercises the priority rule and the fall of the system-error level.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;

   typedef enum logic [1:0] {
      REG_ERRADDR = 2'd0,
      REG_STATUS  = 2'd1,
      REG_CMD     = 2'd2,
      REG_MODE    = 2'd3
   } cfg_reg_e;

   typedef enum logic [1:0] {
      MODE_OFF     = 2'd0,
      MODE_DETECT  = 2'd1,
      MODE_CORRECT = 2'd2,
      MODE_SCRUB   = 2'd3
   } integ_mode_e;

   localparam int unsigned CLS_SB  = 0;
   localparam int unsigned CLS_MB  = 1;
   localparam int unsigned NUM_CLS = 2;

   function automatic logic capture_allowed(input logic [1:0] mode);
      return mode != MODE_OFF;
   endfunction

endpackage

// File: rtl/ecc_err_addr_log.sv
module ecc_err_addr_log #(
   parameter int unsigned BLK_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic             hit_sb,
   input  logic             hit_mb,
   input  logic [BLK_W-1:0] blk_in,
   input  logic             clr_sb,
   input  logic             clr_mb,
   output logic [BLK_W-1:0] blk_q,
   output logic             sb_q,
   output logic             mb_q
);

   logic sb_keep;
   logic mb_keep;
   logic take;

   assign sb_keep = sb_q & ~clr_sb;
   assign mb_keep = mb_q & ~clr_mb;
   assign take    = cap_en & (hit_sb | hit_mb) & ~sb_keep & ~mb_keep;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_q <= '0;
         sb_q  <= 1'b0;
         mb_q  <= 1'b0;
      end else if (take) begin
         blk_q <= blk_in;
         mb_q  <= hit_mb;
         sb_q  <= hit_sb & ~hit_mb;
      end else begin
         sb_q  <= sb_keep;
         mb_q  <= mb_keep;
      end
   end

endmodule

// File: rtl/ecc_err_row_log.sv
module ecc_err_row_log #(
   parameter int unsigned ROW_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic             hit,
   input  logic [ROW_W-1:0] row_in,
   input  logic             clr,
   output logic             flag_q,
   output logic [ROW_W-1:0] row_q
);

   logic flag_keep;

   assign flag_keep = flag_q & ~clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         row_q  <= '0;
      end else if (cap_en && hit && !flag_keep) begin
         flag_q <= 1'b1;
         row_q  <= row_in;
      end else begin
         flag_q <= flag_keep;
      end
   end

endmodule

// File: rtl/ecc_err_cfg_regs.sv
module ecc_err_cfg_regs
   import ecc_err_log_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned BLOCK_SHIFT = 12,
   parameter int unsigned ROW_W       = 3,
   parameter int unsigned STATUS_W    = 16,
   localparam int unsigned BLK_W      = DATA_W - BLOCK_SHIFT,
   localparam int unsigned FIELD_W    = ROW_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               cfg_sel,
   input  logic                     cfg_we,
   input  logic [DATA_W-1:0]        cfg_wdata,
   input  logic [BLK_W-1:0]         blk_q,
   input  logic                     addr_sb_q,
   input  logic                     addr_mb_q,
   input  logic [NUM_CLS-1:0]       cls_flag_q,
   input  logic [NUM_CLS*ROW_W-1:0] cls_row_q,
   output logic [DATA_W-1:0]        cfg_rdata,
   output logic                     clr_addr_sb,
   output logic                     clr_addr_mb,
   output logic [NUM_CLS-1:0]       clr_cls,
   output logic [NUM_CLS-1:0]       cmd_en,
   output logic [1:0]               mode_q
);

   logic                wr_addr;
   logic                wr_status;
   logic                wr_cmd;
   logic                wr_mode;
   logic [STATUS_W-1:0] status_word;
   logic [DATA_W-1:0]   addr_word;

   assign wr_addr   = cfg_we && (cfg_sel == REG_ERRADDR);
   assign wr_status = cfg_we && (cfg_sel == REG_STATUS);
   assign wr_cmd    = cfg_we && (cfg_sel == REG_CMD);
   assign wr_mode   = cfg_we && (cfg_sel == REG_MODE);

   assign clr_addr_sb = wr_addr & cfg_wdata[0];
   assign clr_addr_mb = wr_addr & cfg_wdata[1];

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_clr
      assign clr_cls[c] = wr_status & cfg_wdata[c*FIELD_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_en <= '0;
         mode_q <= MODE_OFF;
      end else begin
         if (wr_cmd)  cmd_en <= cfg_wdata[NUM_CLS-1:0];
         if (wr_mode) mode_q <= cfg_wdata[1:0];
      end
   end

   always_comb begin
      status_word = '0;
      for (int c = 0; c < NUM_CLS; c++) begin
         status_word[c*FIELD_W]           = cls_flag_q[c];
         status_word[c*FIELD_W+1 +: ROW_W] = cls_row_q[c*ROW_W +: ROW_W];
      end
   end

   assign addr_word = {blk_q, {(BLOCK_SHIFT-2){1'b0}}, addr_mb_q, addr_sb_q};

   always_comb begin
      case (cfg_sel)
         REG_ERRADDR: cfg_rdata = addr_word;
         REG_STATUS:  cfg_rdata = {{(DATA_W-STATUS_W){1'b0}}, status_word};
         REG_CMD:     cfg_rdata = {{(DATA_W-NUM_CLS){1'b0}}, cmd_en};
         default:     cfg_rdata = {{(DATA_W-2){1'b0}}, mode_q};
      endcase
   end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_err_log_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned BLOCK_SHIFT = 12,
   parameter int unsigned ROW_W       = 3,
   parameter int unsigned STATUS_W    = 16,
   parameter bit          SERR_REG    = 1'b0,
   localparam int unsigned BLK_W      = ADDR_W - BLOCK_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_sb,
   input  logic              err_mb,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic [ROW_W-1:0]  err_row,
   input  logic [1:0]        cfg_sel,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              serr
);

   if (ADDR_W != DATA_W) begin : g_bad_width
      $error("ecc_err_log: ADDR_W must equal DATA_W");
   end
   if (BLOCK_SHIFT < 2 || BLOCK_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("ecc_err_log: BLOCK_SHIFT out of range");
   end
   if (NUM_CLS*(ROW_W+1) > STATUS_W || STATUS_W > DATA_W) begin : g_bad_status
      $error("ecc_err_log: status fields do not fit");
   end

   logic                     cap_en;
   logic [BLK_W-1:0]         addr_blk_q;
   logic                     addr_sb_q;
   logic                     addr_mb_q;
   logic                     clr_addr_sb;
   logic                     clr_addr_mb;
   logic [NUM_CLS-1:0]       clr_cls;
   logic [NUM_CLS-1:0]       cls_flag_q;
   logic [NUM_CLS*ROW_W-1:0] cls_row_q;
   logic [NUM_CLS-1:0]       cls_hit;
   logic [NUM_CLS-1:0]       cmd_en;
   logic [1:0]               mode_q;
   logic                     serr_raw;

   assign cap_en          = capture_allowed(mode_q);
   assign cls_hit[CLS_SB] = err_sb;
   assign cls_hit[CLS_MB] = err_mb;

   ecc_err_addr_log #(.BLK_W(BLK_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .hit_sb (err_sb),
      .hit_mb (err_mb),
      .blk_in (err_addr[ADDR_W-1:BLOCK_SHIFT]),
      .clr_sb (clr_addr_sb),
      .clr_mb (clr_addr_mb),
      .blk_q  (addr_blk_q),
      .sb_q   (addr_sb_q),
      .mb_q   (addr_mb_q)
   );

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      ecc_err_row_log #(.ROW_W(ROW_W)) u_row (
         .clk    (clk),
         .rst_n  (rst_n),
         .cap_en (cap_en),
         .hit    (cls_hit[c]),
         .row_in (err_row),
         .clr    (clr_cls[c]),
         .flag_q (cls_flag_q[c]),
         .row_q  (cls_row_q[c*ROW_W +: ROW_W])
      );
   end

   ecc_err_cfg_regs #(
      .DATA_W      (DATA_W),
      .BLOCK_SHIFT (BLOCK_SHIFT),
      .ROW_W       (ROW_W),
      .STATUS_W    (STATUS_W)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_sel     (cfg_sel),
      .cfg_we      (cfg_we),
      .cfg_wdata   (cfg_wdata),
      .blk_q       (addr_blk_q),
      .addr_sb_q   (addr_sb_q),
      .addr_mb_q   (addr_mb_q),
      .cls_flag_q  (cls_flag_q),
      .cls_row_q   (cls_row_q),
      .cfg_rdata   (cfg_rdata),
      .clr_addr_sb (clr_addr_sb),
      .clr_addr_mb (clr_addr_mb),
      .clr_cls     (clr_cls),
      .cmd_en      (cmd_en),
      .mode_q      (mode_q)
   );

   assign serr_raw = |(cmd_en & cls_flag_q);

   if (SERR_REG) begin : g_serr_ff
      always_ff @(posedge clk) begin
         if (!rst_n) serr <= 1'b0;
         else        serr <= serr_raw;
      end
   end else begin : g_serr_comb
      assign serr = serr_raw;
   end

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
   parameter int unsigned BLK_W  = 20,
   parameter int unsigned ROW_W  = 3,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              err_sb,
   input logic              err_mb,
   input logic [1:0]        cfg_sel,
   input logic              cfg_we,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              serr,
   input logic [BLK_W-1:0]  addr_blk,
   input logic              addr_sb,
   input logic              addr_mb,
   input logic              sb_flag,
   input logic              mb_flag,
   input logic [ROW_W-1:0]  sb_row,
   input logic [ROW_W-1:0]  mb_row,
   input logic [1:0]        mode
);

   logic addr_clr_wr;
   logic sb_clr_wr;
   logic mb_clr_wr;

   assign addr_clr_wr = cfg_we && cfg_sel == 2'd0 && (cfg_wdata[1:0] != 2'b00);
   assign sb_clr_wr   = cfg_we && cfg_sel == 2'd1 && cfg_wdata[0];
   assign mb_clr_wr   = cfg_we && cfg_sel == 2'd1 && cfg_wdata[ROW_W+1];

   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_sb || addr_mb) && !addr_clr_wr |=> $stable(addr_blk) && (addr_sb || addr_mb));

   assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_sb, addr_mb}));

   assert_mb_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_sb && err_mb && mode != 2'b00 && !addr_sb && !addr_mb |=> addr_mb && !addr_sb);

   assert_sb_row_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sb_flag && !sb_clr_wr |=> sb_flag && $stable(sb_row));

   assert_mb_row_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mb_flag && !mb_clr_wr |=> mb_flag && $stable(mb_row));

   assert_mode_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'b00 && !sb_flag && !mb_flag && !addr_sb && !addr_mb
      |=> !sb_flag && !mb_flag && !addr_sb && !addr_mb);

   assert_serr_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(serr) |-> $past(cfg_we));

endmodule

bind ecc_err_log ecc_err_log_chk #(
   .BLK_W  (BLK_W),
   .ROW_W  (ROW_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .err_sb    (err_sb),
   .err_mb    (err_mb),
   .cfg_sel   (cfg_sel),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .serr      (serr),
   .addr_blk  (addr_blk_q),
   .addr_sb   (addr_sb_q),
   .addr_mb   (addr_mb_q),
   .sb_flag   (cls_flag_q[0]),
   .mb_flag   (cls_flag_q[1]),
   .sb_row    (cls_row_q[ROW_W-1:0]),
   .mb_row    (cls_row_q[2*ROW_W-1:ROW_W]),
   .mode      (mode_q)
);

// File: tb/ecc_err_log_tb.sv
`timescale 1ns/1ps
module ecc_err_log_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        err_sb = 1'b0;
   logic        err_mb = 1'b0;
   logic [31:0] err_addr = '0;
   logic [2:0]  err_row = '0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        serr;

   always #4 clk = ~clk;

   ecc_err_log u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_sb    (err_sb),
      .err_mb    (err_mb),
      .err_addr  (err_addr),
      .err_row   (err_row),
      .cfg_sel   (cfg_sel),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .serr      (serr)
   );

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       tag;
   } exp_item_t;

   exp_item_t exp_q[$];
   event      chk_ev;
   int        n_chk  = 0;
   int        n_fail = 0;
   bit        done   = 1'b0;

   // monitor: pops the expected item and compares it with the port value
   initial begin
      forever begin
         exp_item_t it;
         logic [31:0] act;
         @(chk_ev);
         it  = exp_q.pop_front();
         act = (it.sel < 0) ? {31'b0, serr} : cfg_rdata;
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_val(input int sel, input logic [31:0] exp, input string tag);
      exp_item_t it;
      @(negedge clk);
      if (sel >= 0) cfg_sel = 2'(sel);
      #1;
      it.sel = sel;
      it.exp = exp;
      it.tag = tag;
      exp_q.push_back(it);
      -> chk_ev;
      #1;
   endtask

   task automatic cfg_write(input int sel, input logic [31:0] data);
      @(negedge clk);
      cfg_sel   = 2'(sel);
      cfg_wdata = data;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic err_pulse(input bit sb, input bit mb, input logic [31:0] a, input logic [2:0] r);
      @(negedge clk);
      err_sb   = sb;
      err_mb   = mb;
      err_addr = a;
      err_row  = r;
      @(negedge clk);
      err_sb   = 1'b0;
      err_mb   = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      expect_val(0, 32'h0, "R1 addr reg reset");
      expect_val(1, 32'h0, "R1 status reset");
      expect_val(2, 32'h0, "R10 cmd reset");
      expect_val(3, 32'h0, "R12 mode reset");
      expect_val(-1, 32'h0, "R1 serr reset");

      // mode 00 ignores errors
      err_pulse(1, 1, 32'h1234_5678, 3'd5);
      expect_val(0, 32'h0, "R12 no capture addr in mode 00");
      expect_val(1, 32'h0, "R12 no capture status in mode 00");

      cfg_write(3, 32'h2);
      expect_val(3, 32'h2, "R12 mode readback");

      err_pulse(1, 0, 32'hABCD_EFFF, 3'd3);
      expect_val(0, 32'hABCD_E001, "R2 single-bit capture");
      expect_val(1, 32'h0000_0007, "R6 single-bit status");
      expect_val(-1, 32'h0, "R11 serr low with enables off");

      err_pulse(1, 0, 32'h1111_1000, 3'd6);
      expect_val(0, 32'hABCD_E001, "R5 hold on later single-bit");
      expect_val(1, 32'h0000_0007, "R6 row held");

      err_pulse(0, 1, 32'h2222_2000, 3'd2);
      expect_val(0, 32'hABCD_E001, "R5 hold on later multi-bit");
      expect_val(1, 32'h0000_0057, "R7 multi-bit status");

      cfg_write(2, 32'h3);
      expect_val(2, 32'h3, "R10 cmd readback");
      expect_val(-1, 32'h1, "R11 serr high");

      cfg_write(0, 32'hFFFF_F002);
      expect_val(0, 32'hABCD_E001, "R4 zero bit leaves flag, address read-only");
      cfg_write(0, 32'h1);
      expect_val(0, 32'hABCD_E000, "R4 clear single-bit flag");

      err_pulse(0, 1, 32'h7654_3210, 3'd1);
      expect_val(0, 32'h7654_3002, "R3 multi-bit capture");
      expect_val(1, 32'h0000_0057, "R7 multi-bit row held");

      cfg_write(1, 32'h0000_FFEE);
      expect_val(1, 32'h0000_0057, "R8 non-flag status bits ignore writes");
      cfg_write(1, 32'h1);
      expect_val(1, 32'h0000_0056, "R8 clear single-bit status flag");
      expect_val(-1, 32'h1, "R11 serr held by multi-bit flag");
      cfg_write(2, 32'h1);
      expect_val(-1, 32'h0, "R11 serr falls on enable cleared");
      cfg_write(1, 32'h10);
      expect_val(1, 32'h0000_0046, "R8 clear multi-bit flag, rows kept");

      cfg_write(0, 32'h2);
      expect_val(0, 32'h7654_3000, "R4 clear multi-bit flag");
      cfg_write(3, 32'h1);
      err_pulse(1, 1, 32'h0FED_C000, 3'd4);
      expect_val(0, 32'h0FED_C002, "R9 multi-bit priority on address");
      expect_val(1, 32'h0000_0099, "R9 both status flags set");
      expect_val(-1, 32'h1, "R11 serr rises on enabled single-bit flag");
      cfg_write(1, 32'h11);
      expect_val(-1, 32'h0, "R11 serr falls on flag clear");
      expect_val(1, 32'h0000_0088, "R8 both flags cleared");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule